// File: doc/BRIEF.md
# Endpoint Transmit Status and Toggle Controller

This block keeps the transmit-side state of one endpoint of a full-speed serial bus device. The state is a two-bit status code, the data toggle bit and a transmit-complete flag. When the packet engine reports an IN token addressed to this endpoint, the block picks the reply: a data packet using the current toggle as its PID, a NAK handshake, a STALL handshake, or no reply at all. When the host acknowledges a data packet, the block flips the toggle, sets the status back to NAK and raises the complete flag. All three changes happen on the same clock edge.

Software drives the endpoint through a status write port and a flag-clear strobe. After a completion it clears the flag, loads the next byte count elsewhere, and then writes VALID to arm the next transfer. Until that write, every IN token gets a NAK, which gives flow control. The interrupt request carries the endpoint number and a direction bit, so a shared handler can tell which endpoint needs service.

Top module: `ep_tx_ctrl`

## Requirements
- R1: After reset the status is 00 (disabled), the toggle is 0, the complete flag is 0 and `resp_o` is 00 (none).
- R2: An IN token taken while the status is 11 (VALID) gives `resp_o` = 01 (data) in the cycle after the token. `tog_o` selects DATA0 (0) or DATA1 (1).
- R3: An IN token taken while the status is 10 (NAK) gives `resp_o` = 10 (NAK handshake) in the next cycle, and never 01.
- R4: An IN token taken while the status is 01 (STALL) gives `resp_o` = 11 (STALL handshake) in the next cycle.
- R5: An IN token taken while the status is 00 (disabled) is ignored: `resp_o` stays 00 and no state changes.
- R6: A host ACK taken while the status is 11 flips the toggle, sets the status to 10 and sets the complete flag, all on the same clock edge.
- R7: A cycle without a host ACK, or with an ACK while the status is not 11, leaves the toggle, the status and the flag unchanged, apart from software writes.
- R8: `flag_clr_i` clears the complete flag on the next edge. If a completion arrives in the same cycle, the flag ends up set.
- R9: `irq_o` equals the complete flag. `irq_ep_o` equals `ep_num_i`. `irq_dir_o` is 0, meaning the transmit direction.
- R10: A status write takes effect on the next edge. If an accepted host ACK arrives in the same cycle, the status becomes 10 and the written value is dropped.
- R11: `resp_o` is 00 in every cycle that does not directly follow an IN token.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_tok_i | input | 1 | IN token matched this endpoint (one-cycle strobe) |
| host_ack_i | input | 1 | Host ACK received for the packet just sent |
| stat_we_i | input | 1 | Software status write strobe |
| stat_wdata_i | input | 2 | Status value to write (00 off, 01 stall, 10 NAK, 11 valid) |
| flag_clr_i | input | 1 | Software clear of the transmit-complete flag |
| ep_num_i | input | EP_W | Endpoint number of this instance |
| resp_o | output | 2 | Reply to the last token: 00 none, 01 data, 10 NAK, 11 STALL |
| tog_o | output | 1 | Current data toggle (PID DATA0/DATA1) |
| irq_o | output | 1 | Transmit-complete interrupt request |
| irq_ep_o | output | EP_W | Endpoint number reported with the request |
| irq_dir_o | output | 1 | Direction of the request, 0 for transmit |

## Verification
The bench sweeps every starting status code against every combination of token, ACK, flag clear and status write (with all four write values). After each combination it sends a probe token, so the resulting status is read back through the reply it selects. The ACK cases show the difference between an accepted ACK (status VALID) and an ignored one. Pairing ACK with a flag clear shows which of the two has priority, and pairing ACK with a status write does the same for the status. Token-free cycles show that no reply leaks out, and the disabled status shows that a token can pass with no effect at all.

// File: rtl/ep_tx_pkg.sv
package ep_tx_pkg;
   typedef enum logic [1:0] {
      ST_OFF   = 2'b00,
      ST_STALL = 2'b01,
      ST_NAK   = 2'b10,
      ST_VALID = 2'b11
   } tx_stat_e;

   typedef enum logic [1:0] {
      RSP_NONE  = 2'b00,
      RSP_DATA  = 2'b01,
      RSP_NAK   = 2'b10,
      RSP_STALL = 2'b11
   } tx_resp_e;

   function automatic tx_resp_e stat_to_resp(input tx_stat_e s);
      case (s)
         ST_VALID: return RSP_DATA;
         ST_NAK:   return RSP_NAK;
         ST_STALL: return RSP_STALL;
         default:  return RSP_NONE;
      endcase
   endfunction
endpackage

// File: rtl/ep_tx_state.sv
module ep_tx_state
   import ep_tx_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     ack_i,
   input  logic     we_i,
   input  tx_stat_e wdata_i,
   output tx_stat_e stat_o,
   output logic     tog_o,
   output logic     done_o
);
   tx_stat_e stat_q;
   logic     tog_q;
   logic     ack_ok;

   // an ACK only counts when a data packet could have gone out
   assign ack_ok = ack_i && (stat_q == ST_VALID);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= ST_OFF;
         tog_q  <= 1'b0;
      end else begin
         if (ack_ok) begin
            stat_q <= ST_NAK;
            tog_q  <= ~tog_q;
         end else if (we_i) begin
            stat_q <= wdata_i;
         end
      end
   end

   assign stat_o = stat_q;
   assign tog_o  = tog_q;
   assign done_o = ack_ok;
endmodule

// File: rtl/ep_tx_flag.sv
module ep_tx_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag_q <= 1'b0;
      else if (set_i)  flag_q <= 1'b1;
      else if (clr_i)  flag_q <= 1'b0;
   end

   assign flag_o = flag_q;
endmodule

// File: rtl/ep_tx_resp.sv
module ep_tx_resp
   import ep_tx_pkg::*;
#(
   parameter bit REG_RESP = 1'b1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     tok_i,
   input  tx_stat_e stat_i,
   output tx_resp_e resp_o
);
   tx_resp_e resp_d;

   assign resp_d = tok_i ? stat_to_resp(stat_i) : RSP_NONE;

   generate
      if (REG_RESP) begin : g_reg
         tx_resp_e resp_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) resp_q <= RSP_NONE;
            else        resp_q <= resp_d;
         end
         assign resp_o = resp_q;
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign resp_o = resp_d;
      end
   endgenerate
endmodule

// File: rtl/ep_tx_ctrl.sv
module ep_tx_ctrl
   import ep_tx_pkg::*;
#(
   parameter int EP_W     = 4,
   parameter bit REG_RESP = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_tok_i,
   input  logic            host_ack_i,
   input  logic            stat_we_i,
   input  logic [1:0]      stat_wdata_i,
   input  logic            flag_clr_i,
   input  logic [EP_W-1:0] ep_num_i,
   output logic [1:0]      resp_o,
   output logic            tog_o,
   output logic            irq_o,
   output logic [EP_W-1:0] irq_ep_o,
   output logic            irq_dir_o
);
   localparam logic DIR_TX = 1'b0;

   generate
      if (EP_W < 1 || EP_W > 8) begin : g_bad_w
         $error("ep_tx_ctrl: EP_W must be 1..8");
      end
   endgenerate

   tx_stat_e stat_w;
   tx_resp_e resp_w;
   logic     done_w;
   logic     flag_w;

   ep_tx_state u_state (
      .clk     (clk),
      .rst_n   (rst_n),
      .ack_i   (host_ack_i),
      .we_i    (stat_we_i),
      .wdata_i (tx_stat_e'(stat_wdata_i)),
      .stat_o  (stat_w),
      .tog_o   (tog_o),
      .done_o  (done_w)
   );

   ep_tx_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (done_w),
      .clr_i  (flag_clr_i),
      .flag_o (flag_w)
   );

   ep_tx_resp #(.REG_RESP(REG_RESP)) u_resp (
      .clk    (clk),
      .rst_n  (rst_n),
      .tok_i  (in_tok_i),
      .stat_i (stat_w),
      .resp_o (resp_w)
   );

   assign resp_o    = resp_w;
   assign irq_o     = flag_w;
   assign irq_ep_o  = ep_num_i;
   assign irq_dir_o = DIR_TX;
endmodule

// File: rtl/ep_tx_ctrl_chk.sv
module ep_tx_ctrl_chk #(
   parameter int EP_W     = 4,
   parameter bit REG_RESP = 1'b1
) (
   input logic            clk,
   input logic            rst_n,
   input logic            in_tok_i,
   input logic            host_ack_i,
   input logic            stat_we_i,
   input logic            flag_clr_i,
   input logic [1:0]      stat_q,
   input logic [1:0]      resp_o,
   input logic            tog_o,
   input logic            irq_o,
   input logic [EP_W-1:0] ep_num_i,
   input logic [EP_W-1:0] irq_ep_o
);
   AST_ACK_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
      host_ack_i && stat_q == 2'b11 |=> tog_o != $past(tog_o)); // R6
   AST_ACK_NAK: assert property (@(posedge clk) disable iff (!rst_n)
      host_ack_i && stat_q == 2'b11 |=> stat_q == 2'b10); // R6
   AST_ACK_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      host_ack_i && stat_q == 2'b11 |=> irq_o); // R8
   AST_TOG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(host_ack_i && stat_q == 2'b11) |=> $stable(tog_o)); // R7
   AST_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !host_ack_i && !stat_we_i |=> $stable(stat_q)); // R7
   AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o && !flag_clr_i |=> irq_o); // R8
   AST_IRQ_EP: assert property (@(posedge clk) disable iff (!rst_n)
      irq_ep_o == ep_num_i); // R9
   generate
      if (REG_RESP) begin : g_reg_chk
         AST_NO_TOKEN_NO_RESP: assert property (@(posedge clk) disable iff (!rst_n)
            !in_tok_i |=> resp_o == 2'b00); // R11
         AST_NAK_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
            in_tok_i && stat_q == 2'b10 |=> resp_o == 2'b10); // R3
      end
   endgenerate
endmodule

bind ep_tx_ctrl ep_tx_ctrl_chk #(.EP_W(EP_W), .REG_RESP(REG_RESP)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_tok_i   (in_tok_i),
   .host_ack_i (host_ack_i),
   .stat_we_i  (stat_we_i),
   .flag_clr_i (flag_clr_i),
   .stat_q     (stat_w),
   .resp_o     (resp_o),
   .tog_o      (tog_o),
   .irq_o      (irq_o),
   .ep_num_i   (ep_num_i),
   .irq_ep_o   (irq_ep_o)
);

// File: tb/ep_tx_ctrl_bench.sv
module ep_tx_ctrl_bench;
   localparam int EP_W = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            in_tok_i = 1'b0;
   logic            host_ack_i = 1'b0;
   logic            stat_we_i = 1'b0;
   logic [1:0]      stat_wdata_i = 2'b00;
   logic            flag_clr_i = 1'b0;
   logic [EP_W-1:0] ep_num_i = 4'd5;
   logic [1:0]      resp_o;
   logic            tog_o;
   logic            irq_o;
   logic [EP_W-1:0] irq_ep_o;
   logic            irq_dir_o;

   int n_cmp = 0;
   int n_bad = 0;
   logic [1:0] m_stat = 2'b00;
   logic       m_tog  = 1'b0;
   logic       m_flag = 1'b0;
   bit         done   = 1'b0;

   always #5 clk = ~clk;

   ep_tx_ctrl #(.EP_W(EP_W)) u_ep_tx_ctrl (
      .clk(clk), .rst_n(rst_n), .in_tok_i(in_tok_i), .host_ack_i(host_ack_i),
      .stat_we_i(stat_we_i), .stat_wdata_i(stat_wdata_i), .flag_clr_i(flag_clr_i),
      .ep_num_i(ep_num_i), .resp_o(resp_o), .tog_o(tog_o), .irq_o(irq_o),
      .irq_ep_o(irq_ep_o), .irq_dir_o(irq_dir_o)
   );

   task automatic cmp(input string tag, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   function automatic logic [1:0] exp_resp(input logic [1:0] s);
      // 11->data 01, 10->NAK 10, 01->STALL 11, 00->none 00
      case (s)
         2'b11:   return 2'b01;
         2'b10:   return 2'b10;
         2'b01:   return 2'b11;
         default: return 2'b00;
      endcase
   endfunction

   // one clock: inputs set after a falling edge, outputs checked at the next falling edge
   task automatic cyc(input bit tok, input bit ack, input bit clr, input bit we, input logic [1:0] wv);
      logic [1:0] r_exp;
      bit ack_ok;
      string rtag, ftag;
      in_tok_i = tok; host_ack_i = ack; flag_clr_i = clr;
      stat_we_i = we; stat_wdata_i = wv;
      r_exp  = tok ? exp_resp(m_stat) : 2'b00;
      ack_ok = ack && (m_stat == 2'b11);
      if (!tok)                 rtag = "R11";
      else if (m_stat == 2'b11) rtag = "R2";
      else if (m_stat == 2'b10) rtag = "R3";
      else if (m_stat == 2'b01) rtag = "R4";
      else                      rtag = "R5";
      if (clr)         ftag = "R8";
      else if (ack_ok) ftag = "R6";
      else             ftag = "R7";
      m_tog  = m_tog ^ ack_ok;
      m_flag = ack_ok ? 1'b1 : (clr ? 1'b0 : m_flag);
      m_stat = ack_ok ? 2'b10 : (we ? wv : m_stat); // R10: ack beats write
      @(negedge clk);
      in_tok_i = 0; host_ack_i = 0; flag_clr_i = 0; stat_we_i = 0;
      cmp(rtag, "resp", resp_o, r_exp);
      cmp(ack_ok ? "R6" : "R7", "tog", tog_o, m_tog);
      cmp(ftag, "irq", irq_o, m_flag);
      cmp("R9", "irq_ep", irq_ep_o, ep_num_i);
      cmp("R9", "irq_dir", irq_dir_o, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      cmp("R1", "reset resp", resp_o, 0);
      cmp("R1", "reset tog", tog_o, 0);
      cmp("R1", "reset irq", irq_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
      cyc(1, 0, 0, 0, 2'b00); // R5: disabled token, no reply
      cyc(1, 1, 0, 0, 2'b00); // R7: ack while disabled ignored
      // directed R10: ack and write in same cycle, ack wins
      cyc(0, 0, 0, 1, 2'b11);
      cyc(0, 1, 0, 1, 2'b01);
      cyc(1, 0, 0, 0, 2'b00);
      // directed R8: clear and completion together keep the flag
      cyc(0, 0, 0, 1, 2'b11);
      cyc(0, 1, 1, 0, 2'b00);
      cyc(0, 0, 1, 0, 2'b00);
      // sweep: preset, stimulus, probe token
      for (int s = 0; s < 4; s++)
         for (int st = 0; st < 64; st++) begin
            cyc(0, 0, 0, 1, s[1:0]);
            cyc(st[0], st[1], st[2], st[3], st[5:4]);
            cyc(1, 0, 0, 0, 2'b00);
         end
      // R6/R2: repeated arm and ack cycles alternate DATA0/DATA1
      for (int k = 0; k < 6; k++) begin
         cyc(0, 0, 1, 1, 2'b11);
         cyc(1, 0, 0, 0, 2'b00);
         cyc(0, 1, 0, 0, 2'b00);
         cyc(1, 0, 0, 0, 2'b00);
      end
      done = 1'b1;
   end

   initial begin
      for (int w = 0; w < 20000 && !done; w++) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual hung expected done");
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule